// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Idle Timeout

This block recovers characters from an asynchronous serial line. The line is first passed through a short synchroniser. A 16x oversampling strobe then paces a deframing state machine, which samples each bit near its centre. Each character is handed to an external receive FIFO as a one-cycle push that carries the data and three status flags: parity error, framing error and break. The character length, the parity scheme and the flow-control settings are run-time inputs, so they match whatever the companion transmitter uses.

Two side functions sit next to the deframer. A ready-to-send output tells the far end to pause when the FIFO is almost full. An idle timer raises an interrupt when characters sit in the FIFO unread for a programmed number of character times. The block drives a flush request toward the FIFO while it is disabled or when software asks for one. The FIFO storage and any register access are outside this block.

The deframer states are RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP and RX_RECOVER. The transitions are:
- RX_IDLE to RX_START on a strobe that sees the line low.
- RX_START to RX_DATA when the line is still low on the 8th strobe.
- RX_START to RX_IDLE when the line is high on the 8th strobe, which rejects the start as a glitch.
- RX_DATA to RX_PARITY, or to RX_STOP when parity is off, after the last data bit.
- RX_PARITY to RX_STOP after the parity bit.
- RX_STOP to RX_IDLE when the stop sample is high.
- RX_STOP to RX_RECOVER when the stop sample is low.
- RX_RECOVER to RX_IDLE once the line is high again.
- Any state to RX_IDLE while the block is disabled.

Top module: `serial_rx_core`

## Requirements
- R1: After a low line sample starts a frame, the line is sampled again on the 8th 16x strobe. If it is high, no character is pushed, and the next real frame is received correctly.
- R2: Character size code 0, 1, 2 and 3 selects 5, 6, 7 and 8 data bits. Data arrives least significant bit first and is pushed right-aligned with unused upper bits zero.
- R3: Parity mode code 0 is even, 1 is odd, 2 is mark (bit always 1) and 3 is space (bit always 0). When zero counting is selected, the even or odd result is computed on the inverted data bits. A received parity bit that differs from the expected one sets the parity error flag. With parity disabled, no parity bit is expected and the flag stays 0.
- R4: A low stop-bit sample sets the framing error flag, and the character is still pushed.
- R5: A frame with a low stop sample, all data bits low and the parity bit low or absent sets the break flag together with the framing error. A line held low after it produces no further characters until the line has returned high.
- R6: Each received frame gives exactly one push, one clock wide.
- R7: With flow control on, ready-to-send is asserted when the FIFO reports at least 2 free entries and deasserted otherwise. The polarity input gives the asserted level (0 means low, 1 means high). With flow control off, the output is held at the asserted level.
- R8: The flush output is high while the block is disabled or a flush request is present. Disabling the block abandons a frame in progress without a push.
- R9: The timeout interrupt rises exactly N x T strobes after the last reload while the FIFO is non-empty. Here N is the programmed count and T = 16 x (7 + size code + parity enable). The interrupt is only high while the FIFO is non-empty, and a count of 0 never raises it.
- R10: A FIFO read or a new character push reloads the timeout count and clears the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low holds the deframer idle and requests a flush |
| flush_req | input | 1 | Explicit FIFO flush request |
| tick16 | input | 1 | Strobe at 16 times the bit rate |
| rxd | input | 1 | Serial input line |
| cfg_size | input | 2 | Character size code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | Parity scheme code |
| cfg_par_zeros | input | 1 | Parity counted over zeros instead of ones |
| cfg_flow_en | input | 1 | Flow control enable |
| cfg_flow_pol | input | 1 | Asserted level of ready-to-send |
| cfg_to_chars | input | LIMIT_W | Timeout length in character times (0 disables) |
| fifo_free | input | FREE_W | Free entries in the receive FIFO |
| fifo_empty | input | 1 | Receive FIFO empty |
| fifo_rd | input | 1 | Receive FIFO read strobe |
| fifo_flush | output | 1 | Flush command to the FIFO |
| rx_push | output | 1 | One-cycle push of a received character |
| rx_data | output | DATA_W | Received character, right-aligned |
| rx_perr | output | 1 | Parity error for the pushed character |
| rx_ferr | output | 1 | Framing error for the pushed character |
| rx_brk | output | 1 | Break seen for the pushed character |
| rts | output | 1 | Ready-to-send toward the far end |
| timeout_irq | output | 1 | Idle timeout interrupt |

## Verification
The deframer is driven from a table of frames. The table covers each size code, so a truncation or alignment fault in the shifter is caught. It covers every parity scheme with both counting senses and with correct and flipped parity bits, which separates a wrong polarity from a wrong bit count. It includes low stop bits with non-zero data, with all-zero data and with a mark parity bit, which tells a framing error apart from a true break. Directed runs add a short low pulse that must be rejected, a long held break that must yield a single character, and an abort by disable. Timeout runs measure the exact strobe count to the interrupt, reloaded both by reads and by pushes, so an off-by-one character or a missed reload source shows up.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    // smallest character length; size code adds to this
    localparam int MIN_CHAR = 5;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_RECOVER
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_EVEN  = 2'd0,
        PAR_ODD   = 2'd1,
        PAR_MARK  = 2'd2,
        PAR_SPACE = 2'd3
    } par_mode_e;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // idle line is high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/rx_parity_gen.sv
module rx_parity_gen
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] bits,
    input  logic [1:0]        size,
    input  logic [1:0]        mode,
    input  logic              count_zeros,
    output logic              expect_bit
);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] src;
    logic              odd_cnt;

    // only the active character bits take part
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (i < (MIN_CHAR + int'(size)));
    end

    assign src     = count_zeros ? (~bits & mask) : (bits & mask);
    assign odd_cnt = ^src;

    always_comb begin
        unique case (par_mode_e'(mode))
            PAR_EVEN:  expect_bit = odd_cnt;
            PAR_ODD:   expect_bit = ~odd_cnt;
            PAR_MARK:  expect_bit = 1'b1;
            PAR_SPACE: expect_bit = 1'b0;
            default:   expect_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
    parameter int LIMIT_W = 8,
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               reload,
    input  logic               fifo_empty,
    input  logic [LIMIT_W-1:0] limit,
    input  logic [FRAME_W-1:0] frame_ticks,
    output logic               irq
);

    logic [LIMIT_W-1:0] chars_left;
    logic [FRAME_W-1:0] sub_cnt;
    logic               expired;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chars_left <= '0;
            sub_cnt    <= '0;
            expired    <= 1'b0;
        end else if (reload) begin
            chars_left <= limit;
            sub_cnt    <= '0;
            expired    <= 1'b0;
        end else if (tick && !fifo_empty && (chars_left != '0)) begin
            if (sub_cnt == frame_ticks - 1'b1) begin
                sub_cnt    <= '0;
                chars_left <= chars_left - 1'b1;
                if (chars_left == LIMIT_W'(1)) begin
                    expired <= 1'b1;
                end
            end else begin
                sub_cnt <= sub_cnt + 1'b1;
            end
        end
    end

    assign irq = expired && !fifo_empty;

endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              rxs,
    input  logic [1:0]        size,
    input  logic              par_en,
    input  logic              exp_par,
    output logic [DATA_W-1:0] char_bits,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              push_perr,
    output logic              push_ferr,
    output logic              push_brk
);

    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] SHIFT_MAX = IDX_W'(DATA_W - MIN_CHAR);

    rx_state_e         state, state_nx;
    logic [CNT_W-1:0]  tcnt;
    logic [IDX_W-1:0]  bidx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              mid_start;
    logic              bit_end;
    logic              last_bit;
    logic              stop_done;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  shamt;

    assign mid_start = tick && (tcnt == MID_TICK);
    assign bit_end   = tick && (tcnt == LAST_TICK);
    assign last_idx  = IDX_W'(MIN_CHAR - 1) + IDX_W'(size);
    assign last_bit  = (bidx == last_idx);
    assign shamt     = SHIFT_MAX - IDX_W'(size);
    assign char_bits = shreg >> shamt;
    assign stop_done = run && (state == RX_STOP) && bit_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:    if (tick && !rxs) state_nx = RX_START;
            RX_START:   if (mid_start) state_nx = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:    if (bit_end && last_bit) state_nx = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY:  if (bit_end) state_nx = RX_STOP;
            RX_STOP:    if (bit_end) state_nx = rxs ? RX_IDLE : RX_RECOVER;
            RX_RECOVER: if (rxs) state_nx = RX_IDLE;
            default:    state_nx = RX_IDLE;
        endcase
        if (!run) begin
            state_nx = RX_IDLE;
        end
    end

    // timing counters and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
        end else if (state == RX_IDLE || state == RX_RECOVER) begin
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
        end else if (tick) begin
            if ((state == RX_START && tcnt == MID_TICK) || tcnt == LAST_TICK) begin
                tcnt <= '0;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
            if (state == RX_DATA && tcnt == LAST_TICK) begin
                shreg <= {rxs, shreg[DATA_W-1:1]};
                bidx  <= bidx + 1'b1;
            end
            if (state == RX_PARITY && tcnt == LAST_TICK) begin
                par_bit <= rxs;
            end
        end
    end

    // outputs toward the FIFO
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push      <= 1'b0;
            push_data <= '0;
            push_perr <= 1'b0;
            push_ferr <= 1'b0;
            push_brk  <= 1'b0;
        end else begin
            push <= stop_done;
            if (stop_done) begin
                push_data <= char_bits;
                push_ferr <= !rxs;
                push_perr <= par_en && (par_bit != exp_par);
                push_brk  <= !rxs && (char_bits == '0) && !(par_en && par_bit);
            end
        end
    end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int LIMIT_W     = 8,
    parameter int FREE_W      = 5,
    parameter int RTS_MARGIN  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               flush_req,
    input  logic               tick16,
    input  logic               rxd,
    input  logic [1:0]         cfg_size,
    input  logic               cfg_par_en,
    input  logic [1:0]         cfg_par_mode,
    input  logic               cfg_par_zeros,
    input  logic               cfg_flow_en,
    input  logic               cfg_flow_pol,
    input  logic [LIMIT_W-1:0] cfg_to_chars,
    input  logic [FREE_W-1:0]  fifo_free,
    input  logic               fifo_empty,
    input  logic               fifo_rd,
    output logic               fifo_flush,
    output logic               rx_push,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_perr,
    output logic               rx_ferr,
    output logic               rx_brk,
    output logic               rts,
    output logic               timeout_irq
);

    localparam int FB_W    = $clog2(DATA_W + 4);
    localparam int FRAME_W = $clog2(OVS * (DATA_W + 3) + 1);

    logic              rxs;
    logic [DATA_W-1:0] char_bits;
    logic              exp_par;
    logic [FB_W-1:0]   frame_bits;
    logic [FRAME_W-1:0] frame_ticks;
    logic              room;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxs)
    );

    rx_deframer #(.DATA_W(DATA_W), .OVS(OVS)) u_deframer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .tick     (tick16),
        .rxs      (rxs),
        .size     (cfg_size),
        .par_en   (cfg_par_en),
        .exp_par  (exp_par),
        .char_bits(char_bits),
        .push     (rx_push),
        .push_data(rx_data),
        .push_perr(rx_perr),
        .push_ferr(rx_ferr),
        .push_brk (rx_brk)
    );

    rx_parity_gen #(.DATA_W(DATA_W)) u_parity (
        .bits       (char_bits),
        .size       (cfg_size),
        .mode       (cfg_par_mode),
        .count_zeros(cfg_par_zeros),
        .expect_bit (exp_par)
    );

    // start + data + optional parity + stop, in strobes
    assign frame_bits  = FB_W'(MIN_CHAR + 2) + FB_W'(cfg_size) + FB_W'(cfg_par_en);
    assign frame_ticks = FRAME_W'(frame_bits) * FRAME_W'(OVS);

    rx_idle_timer #(.LIMIT_W(LIMIT_W), .FRAME_W(FRAME_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .reload     (fifo_rd | rx_push | fifo_flush),
        .fifo_empty (fifo_empty),
        .limit      (cfg_to_chars),
        .frame_ticks(frame_ticks),
        .irq        (timeout_irq)
    );

    assign fifo_flush = !enable || flush_req;

    assign room = (fifo_free >= FREE_W'(RTS_MARGIN));
    assign rts  = (cfg_flow_en && !room) ? ~cfg_flow_pol : cfg_flow_pol;

endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic fifo_rd,
    input logic fifo_empty,
    input logic cfg_par_en,
    input logic rx_push,
    input logic rx_perr,
    input logic rx_ferr,
    input logic rx_brk,
    input logic timeout_irq
);

    // R6
    push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);

    // R8
    off_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !rx_push);

    // R5
    break_implies_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_brk) |-> rx_ferr);

    // R3
    nopar_no_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !$past(cfg_par_en)) |-> !rx_perr);

    // R9
    irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_irq |-> !fifo_empty);

    // R10
    read_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> !timeout_irq);

endmodule

bind serial_rx_core serial_rx_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .fifo_rd    (fifo_rd),
    .fifo_empty (fifo_empty),
    .cfg_par_en (cfg_par_en),
    .rx_push    (rx_push),
    .rx_perr    (rx_perr),
    .rx_ferr    (rx_ferr),
    .rx_brk     (rx_brk),
    .timeout_irq(timeout_irq)
);

// File: tb/serial_rx_core_bench.sv
`timescale 1ns/1ps
module serial_rx_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       flush_req = 1'b0;
    logic       tick16 = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] cfg_size = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_mode = 2'd0;
    logic       cfg_par_zeros = 1'b0;
    logic       cfg_flow_en = 1'b0;
    logic       cfg_flow_pol = 1'b0;
    logic [7:0] cfg_to_chars = 8'd0;
    logic [4:0] fifo_free = 5'd8;
    logic       fifo_empty = 1'b1;
    logic       fifo_rd = 1'b0;
    logic       fifo_flush;
    logic       rx_push;
    logic [7:0] rx_data;
    logic       rx_perr;
    logic       rx_ferr;
    logic       rx_brk;
    logic       rts;
    logic       timeout_irq;

    int checks = 0;
    int errors = 0;
    int push_cnt = 0;
    int push_cyc = 0;
    int cyc = 0;
    logic [7:0] last_data = '0;
    logic last_perr = 1'b0;
    logic last_ferr = 1'b0;
    logic last_brk = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_rx_core u_serial_rx_core (
        .clk(clk), .rst_n(rst_n), .enable(enable), .flush_req(flush_req),
        .tick16(tick16), .rxd(rxd), .cfg_size(cfg_size), .cfg_par_en(cfg_par_en),
        .cfg_par_mode(cfg_par_mode), .cfg_par_zeros(cfg_par_zeros),
        .cfg_flow_en(cfg_flow_en), .cfg_flow_pol(cfg_flow_pol),
        .cfg_to_chars(cfg_to_chars), .fifo_free(fifo_free), .fifo_empty(fifo_empty),
        .fifo_rd(fifo_rd), .fifo_flush(fifo_flush), .rx_push(rx_push),
        .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
        .rts(rts), .timeout_irq(timeout_irq)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rx_push) begin
            push_cnt  = push_cnt + 1;
            push_cyc  = cyc;
            last_data = rx_data;
            last_perr = rx_perr;
            last_ferr = rx_ferr;
            last_brk  = rx_brk;
        end
    end

    typedef struct packed {
        logic [1:0] size;
        logic       par_en;
        logic [1:0] mode;
        logic       zeros;
        logic [7:0] data;
        logic       flip;
        logic       stop;
        logic       e_perr;
        logic       e_ferr;
        logic       e_brk;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{2'd3, 1'b0, 2'd0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'd0, 1'b0, 2'd0, 1'b0, 8'h3F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'd1, 1'b1, 2'd0, 1'b0, 8'h2D, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'd2, 1'b1, 2'd1, 1'b0, 8'h15, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{2'd3, 1'b1, 2'd2, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'd3, 1'b1, 2'd3, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{2'd3, 1'b1, 2'd0, 1'b1, 8'h0F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'd0, 1'b1, 2'd1, 1'b1, 8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{2'd3, 1'b0, 2'd0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'd3, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        '{2'd3, 1'b1, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        '{2'd3, 1'b1, 2'd2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic bit ref_parity(input logic [7:0] d, input int nbits,
                                      input logic [1:0] mode, input bit zeros);
        int cnt = 0;
        for (int k = 0; k < nbits; k++) begin
            if (d[k] != zeros) cnt++;
        end
        case (mode)
            2'd0:    return (cnt % 2) == 1;
            2'd1:    return (cnt % 2) == 0;
            2'd2:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nbits, input bit pen,
                              input bit pbit, input bit stopv, input int hold_low);
        drive_bit(1'b0);
        for (int k = 0; k < nbits; k++) drive_bit(d[k]);
        if (pen) drive_bit(pbit);
        drive_bit(stopv);
        if (!stopv) begin
            rxd = 1'b0;
            repeat (hold_low) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic pulse_read();
        fifo_rd = 1'b1;
        @(negedge clk);
        fifo_rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int pre;
        int base;
        int fr;
        repeat (5) @(negedge clk);
        // reset state (R8, R7)
        check(rx_push == 1'b0, "R6 reset push", 32'(rx_push), 0);
        check(timeout_irq == 1'b0, "R9 reset irq", 32'(timeout_irq), 0);
        check(fifo_flush == 1'b1, "R8 reset flush while disabled", 32'(fifo_flush), 1);
        check(rts == 1'b0, "R7 reset rts flow off", 32'(rts), 0);
        rst_n = 1'b1;
        enable = 1'b1;
        repeat (4) @(negedge clk);
        check(fifo_flush == 1'b0, "R8 flush low when enabled", 32'(fifo_flush), 0);

        // table of frames: R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            int nb;
            bit pb;
            logic [7:0] exp_d;
            v = VECS[i];
            cfg_size = v.size;
            cfg_par_en = v.par_en;
            cfg_par_mode = v.mode;
            cfg_par_zeros = v.zeros;
            @(negedge clk);
            nb = 5 + int'(v.size);
            pb = ref_parity(v.data, nb, v.mode, v.zeros) ^ v.flip;
            exp_d = 8'((1 << nb) - 1) & v.data;
            pre = push_cnt;
            send_frame(v.data, nb, v.par_en, pb, v.stop, 0);
            check(push_cnt == pre + 1, "R6 one push per frame", 32'(push_cnt - pre), 1);
            check(last_data == exp_d, "R2 data", 32'(last_data), 32'(exp_d));
            check(last_perr == v.e_perr, "R3 parity flag", 32'(last_perr), 32'(v.e_perr));
            check(last_ferr == v.e_ferr, "R4 framing flag", 32'(last_ferr), 32'(v.e_ferr));
            check(last_brk == v.e_brk, "R5 break flag", 32'(last_brk), 32'(v.e_brk));
        end

        // R1: short low pulse rejected, then a good frame
        cfg_size = 2'd3; cfg_par_en = 1'b0;
        @(negedge clk);
        pre = push_cnt;
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        check(push_cnt == pre, "R1 glitch gives no push", 32'(push_cnt - pre), 0);
        send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b1, 0);
        check(push_cnt == pre + 1 && last_data == 8'h3C, "R1 frame after glitch",
              32'(last_data), 32'h3C);

        // R5: long break held low yields a single character
        pre = push_cnt;
        send_frame(8'h00, 8, 1'b0, 1'b0, 1'b0, 120);
        check(push_cnt == pre + 1, "R5 held break single push", 32'(push_cnt - pre), 1);
        check(last_brk == 1'b1, "R5 held break flagged", 32'(last_brk), 1);

        // R8: disable in mid frame
        pre = push_cnt;
        rxd = 1'b0;
        repeat (40) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(fifo_flush == 1'b1, "R8 flush when disabled", 32'(fifo_flush), 1);
        repeat (150) @(negedge clk);
        rxd = 1'b1;
        repeat (30) @(negedge clk);
        check(push_cnt == pre, "R8 aborted frame not pushed", 32'(push_cnt - pre), 0);
        enable = 1'b1;
        flush_req = 1'b1;
        @(negedge clk);
        check(fifo_flush == 1'b1, "R8 flush request", 32'(fifo_flush), 1);
        flush_req = 1'b0;
        @(negedge clk);
        check(fifo_flush == 1'b0, "R8 flush released", 32'(fifo_flush), 0);

        // R7: ready-to-send
        cfg_flow_en = 1'b1; cfg_flow_pol = 1'b0; fifo_free = 5'd1;
        @(negedge clk);
        check(rts == 1'b1, "R7 low-active, one free", 32'(rts), 1);
        fifo_free = 5'd2;
        @(negedge clk);
        check(rts == 1'b0, "R7 low-active, two free", 32'(rts), 0);
        cfg_flow_pol = 1'b1; fifo_free = 5'd0;
        @(negedge clk);
        check(rts == 1'b0, "R7 high-active, full", 32'(rts), 0);
        fifo_free = 5'd7;
        @(negedge clk);
        check(rts == 1'b1, "R7 high-active, room", 32'(rts), 1);
        cfg_flow_en = 1'b0; fifo_free = 5'd0;
        @(negedge clk);
        check(rts == 1'b1, "R7 flow off held asserted", 32'(rts), 1);

        // R9: exact timeout, 5-bit no parity => 112 strobes per character
        cfg_size = 2'd0; cfg_par_en = 1'b0; cfg_to_chars = 8'd2;
        fr = 112;
        fifo_empty = 1'b0;
        pulse_read();
        base = cyc;
        wait_until(base + 2 * fr - 1);
        check(timeout_irq == 1'b0, "R9 irq not yet", 32'(timeout_irq), 0);
        wait_until(base + 2 * fr);
        check(timeout_irq == 1'b1, "R9 irq on time", 32'(timeout_irq), 1);
        fifo_empty = 1'b1;
        @(negedge clk);
        check(timeout_irq == 1'b0, "R9 irq needs data", 32'(timeout_irq), 0);
        fifo_empty = 1'b0;

        // R10: read clears and reloads
        pulse_read();
        base = cyc;
        check(timeout_irq == 1'b0, "R10 read clears irq", 32'(timeout_irq), 0);
        repeat (150) @(negedge clk);
        pulse_read();
        base = cyc;
        wait_until(base + 2 * fr - 1);
        check(timeout_irq == 1'b0, "R10 read reload, not yet", 32'(timeout_irq), 0);
        wait_until(base + 2 * fr);
        check(timeout_irq == 1'b1, "R10 read reload, fires", 32'(timeout_irq), 1);

        // R9: count of zero never fires
        cfg_to_chars = 8'd0;
        pulse_read();
        repeat (400) @(negedge clk);
        check(timeout_irq == 1'b0, "R9 zero count disabled", 32'(timeout_irq), 0);

        // R10: a push reloads, 8-bit no parity => 160 strobes per character
        cfg_size = 2'd3; cfg_to_chars = 8'd2;
        fr = 160;
        pulse_read();
        pre = push_cnt;
        send_frame(8'h11, 8, 1'b0, 1'b0, 1'b1, 0);
        check(push_cnt == pre + 1, "R10 push seen", 32'(push_cnt - pre), 1);
        wait_until(push_cyc + 2 * fr);
        check(timeout_irq == 1'b0, "R10 push reload, not yet", 32'(timeout_irq), 0);
        wait_until(push_cyc + 2 * fr + 1);
        check(timeout_irq == 1'b1, "R10 push reload, fires", 32'(timeout_irq), 1);

        finish_run();
    end

endmodule